// File: doc/BRIEF.md
# Collapsed Three-Input ALU for Fused Instruction Pairs

This execution unit evaluates a dependent pair of simple integer operations in a single pass. A head operation combines operands A and B; a tail operation takes the head's value as its first input and operand C as its second, so the unit yields tail(head(A, B), C). Operand C is normally an immediate or a repeat of one of the two register sources. A fused pair then takes one issue slot instead of two, and a single unfused operation goes through the same unit with the tail bypassed.

The tail may be a full ALU operation. It may also be a conditional branch that resolves from the head's flags, or an address-generation step that adds a displacement to the head's value for a following memory access. The intermediate head value is always returned on its own port. Its valid flag is raised when the pair also writes the head's destination. Every input is captured into output registers, so results appear one clock after the operation is presented.

Top module: `fused_alu3`

## Requirements
- R1: While rst_ni is low, every output is zero.
- R2: Outputs are registered. valid_o is valid_i delayed by one clock. In any cycle where valid_o is 0, result_o, head_res_o, flags_o, head_valid_o and taken_o are all 0.
- R3: With fused_i = 0, result_o equals the head value, flags_o holds the head flags, and head_valid_o and taken_o are 0.
- R4: With fused_i = 1 and an ALU tail (code 0 to 8), result_o = tail(head(A,B), C) and flags_o holds the tail flags. This includes a head add followed by a tail AND with an immediate mask.
- R5: head_res_o carries the head value for every valid operation. head_valid_o = fused_i AND head_live_i.
- R6: Op codes are 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 shift left, 6 logical shift right, 7 arithmetic shift right, 8 compare, 9 branch (tail only) and 10 address generation (tail only). The flags vector is {overflow[3], carry[2], sign[1], zero[0]}. For add, carry is the carry-out. For subtract, carry is the borrow (first operand below second, unsigned). Overflow is signed two's-complement overflow.
- R7: Shifts take their amount from the low log2(WIDTH) bits of the second operand. The arithmetic right shift fills with the sign bit.
- R8: Compare returns its first operand unchanged as its value. It sets flags as a subtraction of the second operand from the first.
- R9: With tail code 9, result_o is the head value, flags_o holds the head flags, and taken_o is the condition cond_i applied to the head flags. The conditions are 0 equal (Z), 1 not equal, 2 signed less (S xor V), 3 signed greater-or-equal, 4 unsigned less (C), 5 unsigned greater-or-equal, 6 always and 7 never.
- R10: With tail code 10, result_o = head value + C (modulo 2^WIDTH) and flags_o holds the head flags.
- R11: And, or, xor and the shifts clear carry and overflow. Zero and sign are taken from their result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| fused_i | input | 1 | Tail operation is applied |
| head_live_i | input | 1 | Head destination is written as well |
| head_op_i | input | 4 | Head op code (0 to 8) |
| tail_op_i | input | 4 | Tail op code (0 to 10) |
| cond_i | input | 3 | Branch condition for tail code 9 |
| src_a_i | input | WIDTH | Head first operand |
| src_b_i | input | WIDTH | Head second operand or immediate |
| src_c_i | input | WIDTH | Tail second operand, immediate or displacement |
| valid_o | output | 1 | Registered valid |
| result_o | output | WIDTH | Primary result |
| head_res_o | output | WIDTH | Intermediate head value |
| head_valid_o | output | 1 | Head value is to be written |
| flags_o | output | 4 | {V, C, S, Z} |
| taken_o | output | 1 | Branch outcome |

## Verification
The assertions assume that any presented operation carries a head code from 0 to 8, since only single-cycle ALU operations may lead a pair. The stimulus picks head codes only from that range and uses the full range of tail codes and conditions. The other properties tie registered outputs to the previous cycle's valid, fused and tail-code inputs, so they need only known control inputs, which the bench always drives. Directed cases cover signed and unsigned overflow edges, shift amounts that exceed the field, equal and unordered compares, and bubbles with nonzero operands.

// File: rtl/fa3_pkg.sv
package fa3_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_SHL  = 4'd5,
    OP_SHR  = 4'd6,
    OP_SAR  = 4'd7,
    OP_CMP  = 4'd8,
    OP_BR   = 4'd9,
    OP_AGEN = 4'd10
  } op_e;

  typedef enum logic [2:0] {
    CC_EQ, CC_NE, CC_LT, CC_GE, CC_LTU, CC_GEU, CC_ALWAYS, CC_NEVER
  } cc_e;

  typedef struct packed {
    logic v;
    logic c;
    logic s;
    logic z;
  } flags_t;
endpackage

// File: rtl/fa3_alu_stage.sv
module fa3_alu_stage
  import fa3_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  op_e              op_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  output logic [WIDTH-1:0] res_o,
  output flags_t           flags_o
);
  localparam int SHW = $clog2(WIDTH);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   sum, dif;
  logic [SHW-1:0]   sh;
  logic [WIDTH-1:0] fsrc;
  logic             add_ovf, sub_ovf;

  assign sum     = {1'b0, opa_i} + {1'b0, opb_i};
  assign dif     = {1'b0, opa_i} - {1'b0, opb_i};
  assign sh      = opb_i[SHW-1:0];
  assign add_ovf = (opa_i[MSB] == opb_i[MSB]) && (sum[MSB] != opa_i[MSB]);
  assign sub_ovf = (opa_i[MSB] != opb_i[MSB]) && (dif[MSB] != opa_i[MSB]);

  // R6 R7 R8 R11
  always_comb begin
    res_o     = sum[WIDTH-1:0];
    fsrc      = sum[WIDTH-1:0];
    flags_o.c = sum[WIDTH];
    flags_o.v = add_ovf;
    unique case (op_i)
      OP_SUB: begin
        res_o = dif[WIDTH-1:0]; fsrc = dif[WIDTH-1:0];
        flags_o.c = dif[WIDTH]; flags_o.v = sub_ovf;
      end
      OP_CMP: begin
        res_o = opa_i; fsrc = dif[WIDTH-1:0];
        flags_o.c = dif[WIDTH]; flags_o.v = sub_ovf;
      end
      OP_AND, OP_OR, OP_XOR, OP_SHL, OP_SHR, OP_SAR: begin
        unique case (op_i)
          OP_AND:  res_o = opa_i & opb_i;
          OP_OR:   res_o = opa_i | opb_i;
          OP_XOR:  res_o = opa_i ^ opb_i;
          OP_SHL:  res_o = opa_i << sh;
          OP_SHR:  res_o = opa_i >> sh;
          default: res_o = WIDTH'($signed(opa_i) >>> sh);
        endcase
        fsrc = res_o; flags_o.c = 1'b0; flags_o.v = 1'b0;
      end
      default: ;
    endcase
    flags_o.z = (fsrc == '0);
    flags_o.s = fsrc[MSB];
  end
endmodule

// File: rtl/fa3_cond_eval.sv
module fa3_cond_eval
  import fa3_pkg::*;
(
  input  cc_e    cc_i,
  input  flags_t fl_i,
  output logic   hit_o
);
  // R9
  always_comb begin
    unique case (cc_i)
      CC_EQ:     hit_o = fl_i.z;
      CC_NE:     hit_o = !fl_i.z;
      CC_LT:     hit_o = fl_i.s ^ fl_i.v;
      CC_GE:     hit_o = !(fl_i.s ^ fl_i.v);
      CC_LTU:    hit_o = fl_i.c;
      CC_GEU:    hit_o = !fl_i.c;
      CC_ALWAYS: hit_o = 1'b1;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fused_alu3.sv
module fused_alu3
  import fa3_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             fused_i,
  input  logic             head_live_i,
  input  logic [3:0]       head_op_i,
  input  logic [3:0]       tail_op_i,
  input  logic [2:0]       cond_i,
  input  logic [WIDTH-1:0] src_a_i,
  input  logic [WIDTH-1:0] src_b_i,
  input  logic [WIDTH-1:0] src_c_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] result_o,
  output logic [WIDTH-1:0] head_res_o,
  output logic             head_valid_o,
  output logic [3:0]       flags_o,
  output logic             taken_o
);
  op_e              hop, top, tstage_op;
  logic [WIDTH-1:0] h_res, t_res, nxt_res;
  flags_t           h_fl, t_fl, nxt_fl;
  logic             tail_alu, cond_hit, nxt_taken;

  assign hop       = op_e'(head_op_i);
  assign top       = op_e'(tail_op_i);
  assign tail_alu  = fused_i && (tail_op_i <= 4'(OP_CMP));
  // address generation reuses the tail adder
  assign tstage_op = (tail_op_i <= 4'(OP_CMP)) ? top : OP_ADD;

  fa3_alu_stage #(.WIDTH(WIDTH)) u_head (
    .op_i(hop), .opa_i(src_a_i), .opb_i(src_b_i), .res_o(h_res), .flags_o(h_fl)
  );

  fa3_alu_stage #(.WIDTH(WIDTH)) u_tail (
    .op_i(tstage_op), .opa_i(h_res), .opb_i(src_c_i), .res_o(t_res), .flags_o(t_fl)
  );

  fa3_cond_eval u_cond (
    .cc_i(cc_e'(cond_i)), .fl_i(h_fl), .hit_o(cond_hit)
  );

  // R3 R4 R9 R10
  always_comb begin
    nxt_res   = h_res;
    nxt_fl    = h_fl;
    nxt_taken = 1'b0;
    if (tail_alu) begin
      nxt_res = t_res;
      nxt_fl  = t_fl;
    end else if (fused_i && top == OP_AGEN) begin
      nxt_res = t_res;
    end else if (fused_i && top == OP_BR) begin
      nxt_taken = cond_hit;
    end
  end

  // R1 R2 R5
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      result_o     <= '0;
      head_res_o   <= '0;
      head_valid_o <= 1'b0;
      flags_o      <= '0;
      taken_o      <= 1'b0;
    end else if (valid_i) begin
      valid_o      <= 1'b1;
      result_o     <= nxt_res;
      head_res_o   <= h_res;
      head_valid_o <= fused_i && head_live_i;
      flags_o      <= nxt_fl;
      taken_o      <= nxt_taken;
    end else begin
      valid_o      <= 1'b0;
      result_o     <= '0;
      head_res_o   <= '0;
      head_valid_o <= 1'b0;
      flags_o      <= '0;
      taken_o      <= 1'b0;
    end
  end

  p_head_single_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> head_op_i <= 4'(OP_CMP));

  p_valid_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (result_o == '0 && flags_o == '0 && !taken_o && !head_valid_o));

  p_unfused_side_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !fused_i) |=> (!head_valid_o && !taken_o));

  p_branch_passes_head_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fused_i && tail_op_i == 4'(OP_BR)) |=> (result_o == head_res_o));

  p_taken_only_branch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !(fused_i && tail_op_i == 4'(OP_BR))) |=> !taken_o);
endmodule

// File: tb/fused_alu3_bench.sv
module fused_alu3_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam longint unsigned M = 64'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 0, fused_i = 0, head_live_i = 0;
  logic [3:0] head_op_i = 0, tail_op_i = 0;
  logic [2:0] cond_i = 0;
  logic [W-1:0] src_a_i = 0, src_b_i = 0, src_c_i = 0;
  logic valid_o, head_valid_o, taken_o;
  logic [W-1:0] result_o, head_res_o;
  logic [3:0] flags_o;

  int checks = 0;
  int fails = 0;

  typedef struct {
    bit vld; longint unsigned res; longint unsigned hres;
    bit hv; bit [3:0] fl; bit tk; string tag;
  } exp_t;
  exp_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fused_alu3 #(.WIDTH(W)) u_fused_alu3 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .fused_i(fused_i),
    .head_live_i(head_live_i), .head_op_i(head_op_i), .tail_op_i(tail_op_i),
    .cond_i(cond_i), .src_a_i(src_a_i), .src_b_i(src_b_i), .src_c_i(src_c_i),
    .valid_o(valid_o), .result_o(result_o), .head_res_o(head_res_o),
    .head_valid_o(head_valid_o), .flags_o(flags_o), .taken_o(taken_o)
  );

  function automatic bit sgn(longint unsigned x);
    return bit'((x >> 31) & 1);
  endfunction

  // behavioural op model: flags {v,c,s,z}
  function automatic void op_ref(int op, longint unsigned a, longint unsigned b,
                                 output longint unsigned r, output bit [3:0] fl);
    longint unsigned f;
    bit c, v;
    int sh;
    sh = int'(b & 31);
    c = 0; v = 0;
    case (op)
      1, 8: begin
        f = (a - b) & M; c = (a < b); v = (sgn(a) != sgn(b)) && (sgn(f) != sgn(a));
        r = (op == 8) ? a : f;
      end
      2: begin r = a & b; f = r; end
      3: begin r = a | b; f = r; end
      4: begin r = a ^ b; f = r; end
      5: begin r = (a << sh) & M; f = r; end
      6: begin r = a >> sh; f = r; end
      7: begin
        r = a >> sh;
        if (sgn(a)) r = r | ((M << (32 - sh)) & M);
        f = r;
      end
      default: begin
        f = (a + b); c = bit'(f >> 32); f = f & M;
        v = (sgn(a) == sgn(b)) && (sgn(f) != sgn(a)); r = f;
      end
    endcase
    fl = {v, c, sgn(f), f == 0};
  endfunction

  function automatic bit cond_ref(int cc, bit [3:0] fl);
    case (cc)
      0: return fl[0];
      1: return !fl[0];
      2: return fl[1] != fl[3];
      3: return fl[1] == fl[3];
      4: return fl[2];
      5: return !fl[2];
      6: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check_out();
    exp_t e;
    if (expq.size() == 0) return;
    e = expq.pop_front();
    checks++;
    if (valid_o !== e.vld || result_o !== W'(e.res) || head_res_o !== W'(e.hres) ||
        head_valid_o !== e.hv || flags_o !== e.fl || taken_o !== e.tk) begin
      fails++;
      $display("FAIL %s actual v=%0b r=%h h=%h hv=%0b f=%h t=%0b expected v=%0b r=%h h=%h hv=%0b f=%h t=%0b",
               e.tag, valid_o, result_o, head_res_o, head_valid_o, flags_o, taken_o,
               e.vld, W'(e.res), W'(e.hres), e.hv, e.fl, e.tk);
    end
  endtask

  task automatic drive(string tag, bit v, bit f, bit live, int hop, int top, int cc,
                       longint unsigned a, longint unsigned b, longint unsigned c);
    exp_t e;
    longint unsigned h, t;
    bit [3:0] hf, tf;
    @(negedge clk);
    check_out();
    valid_i = v; fused_i = f; head_live_i = live;
    head_op_i = 4'(hop); tail_op_i = 4'(top); cond_i = 3'(cc);
    src_a_i = W'(a); src_b_i = W'(b); src_c_i = W'(c);
    e = '{vld: 0, res: 0, hres: 0, hv: 0, fl: 0, tk: 0, tag: tag};
    if (v) begin
      op_ref(hop, a, b, h, hf);
      e.vld = 1; e.hres = h; e.res = h; e.fl = hf;
      if (f) begin
        e.hv = live;
        if (top <= 8) begin
          op_ref(top, h, c, t, tf); e.res = t; e.fl = tf;
        end else if (top == 10) begin
          e.res = (h + c) & M;
        end else if (top == 9) begin
          e.tk = cond_ref(cc, hf);
        end
      end
    end
    expq.push_back(e);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    valid_i = 1; fused_i = 1; head_live_i = 1; src_a_i = 32'h1234;
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (valid_o !== 0 || result_o !== 0 || head_res_o !== 0 || head_valid_o !== 0 ||
        flags_o !== 0 || taken_o !== 0) begin
      fails++;
      $display("FAIL R1 actual v=%0b r=%h f=%h expected all zero", valid_o, result_o, flags_o);
    end
    valid_i = 0; fused_i = 0; head_live_i = 0;
    rst_ni = 1'b1;

    // R4 add then mask with immediate, head live (R5)
    drive("R4", 1, 1, 1, 0, 2, 0, 64'h1000, 1, 64'h7f);
    drive("R5", 1, 1, 0, 0, 2, 0, 64'h10ff, 1, 64'h7f);
    // R6 add overflow / carry, subtract borrow
    drive("R6", 1, 0, 0, 0, 0, 0, 64'h7fff_ffff, 1, 0);
    drive("R6", 1, 0, 0, 0, 0, 0, 64'hffff_ffff, 1, 0);
    drive("R6", 1, 0, 0, 1, 0, 0, 1, 2, 0);
    drive("R6", 1, 1, 0, 1, 1, 0, 64'h8000_0000, 1, 1);
    // R7 shifts: amount from low bits only
    drive("R7", 1, 0, 0, 7, 0, 0, 64'h8000_0000, 4, 0);
    drive("R7", 1, 0, 0, 5, 0, 0, 3, 31, 0);
    drive("R7", 1, 0, 0, 6, 0, 0, 64'hf000_0000, 64'h25, 0);
    drive("R7", 1, 1, 1, 0, 7, 0, 64'hff00_0000, 0, 64'h48);
    // R8 compare passes first operand
    drive("R8", 1, 0, 0, 8, 0, 0, 5, 5, 0);
    drive("R8", 1, 0, 0, 8, 0, 0, 3, 7, 0);
    // R9 compare-and-branch
    drive("R9", 1, 1, 0, 8, 9, 0, 5, 5, 0);
    drive("R9", 1, 1, 0, 8, 9, 1, 5, 5, 0);
    drive("R9", 1, 1, 0, 8, 9, 4, 3, 7, 0);
    drive("R9", 1, 1, 0, 8, 9, 2, 64'hffff_fffe, 1, 0);
    drive("R9", 1, 1, 0, 8, 9, 5, 64'hffff_fffe, 1, 0);
    drive("R9", 1, 1, 1, 1, 9, 3, 64'h8000_0000, 1, 0);
    drive("R9", 1, 1, 0, 8, 9, 7, 0, 0, 0);
    drive("R9", 1, 1, 0, 8, 9, 6, 0, 0, 0);
    // R10 address generation
    drive("R10", 1, 1, 1, 0, 10, 0, 64'hffff_fff0, 64'h8, 64'h7c);
    // R11 logic tail clears carry/overflow
    drive("R11", 1, 1, 0, 0, 4, 0, 64'hffff_ffff, 1, 0);
    drive("R11", 1, 1, 0, 2, 3, 0, 64'hf0f0, 64'hff, 64'h8000_0000);
    // R3 unfused ignores tail, live and cond
    drive("R3", 1, 0, 1, 1, 9, 6, 10, 3, 99);
    // R2 bubble with busy operands
    drive("R2", 0, 1, 1, 0, 9, 6, 64'hdead, 64'hbeef, 1);
    drive("R2", 1, 1, 1, 0, 0, 0, 1, 2, 3);

    for (int i = 0; i < 3000; i++) begin
      int hop, top;
      string tg;
      bit v, f;
      hop = int'($urandom_range(0, 8));
      top = int'($urandom_range(0, 10));
      v = ($urandom_range(0, 7) != 0);
      f = ($urandom_range(0, 3) != 0);
      if (!v) tg = "R2";
      else if (!f) tg = "R3";
      else if (top == 9) tg = "R9";
      else if (top == 10) tg = "R10";
      else tg = "R4";
      drive(tg, v, f, 1'($urandom()), hop, top, int'($urandom_range(0, 7)),
            ($urandom_range(0, 3) == 0) ? 64'h8000_0000 : longint'($urandom()),
            ($urandom_range(0, 3) == 0) ? 64'h7fff_ffff : longint'($urandom()),
            longint'($urandom()));
    end
    @(negedge clk);
    check_out();
    finish_run();
  end
endmodule